// File: doc/BRIEF.md
# Octave Decimation Filter Bank

This block runs a chain of eleven decimate-by-two FIR stages on a single shared multiply-accumulate engine. One input stream enters at the top rate. The first stage filters it, and every second result position carries on down the chain. Each later stage therefore works at half the rate of the stage above it. All stages use one common coefficient set. Each stage keeps its own sample history, so the stages never disturb each other's state.

A channel time-slicer that assumes one common rate cannot serve stages whose rates differ by powers of two. Instead, each accepted input sample opens one scheduling slot, and a free-running slot counter chooses which stage the engine serves in that slot. Stage 0 gets every odd slot, stage 1 gets every slot that is 2 mod 4, and so on. Each stage is served exactly at its own output rate. Every result leaves on the output port tagged with the stage that produced it. The same result is also pushed into the history of the next stage.

Top module: `octdec_bank`

## Requirements
- R1: A synchronous active-high reset clears every stage history, the slot counter and the accumulator. Right after reset, inReady is 1 and outValid is 0, and the first results after reset are computed from zero histories.
- R2: An 11-bit slot counter counts accepted samples modulo 2048. For the k-th accepted sample (k mod 2048 not 0), exactly one result is produced, and its outStage equals the number of trailing zero bits of k mod 2048.
- R3: When k mod 2048 is 0, the slot is idle. No result is produced and inReady stays 1.
- R4: Every accepted input sample is shifted into the stage 0 history. Every result of stage j (j < 10) is shifted into the history of stage j+1 only. Stage 10 results go only to the output.
- R5: A result of stage j is acc = sum over t = 0..15 of c[t]·h_j[t], where h_j[0] is the newest sample in that stage's history. The shared coefficients are c[t] = U·(t+1) for t < 8 and U·(16−t) otherwise, with U = 455 by default.
- R6: The result is rounded as (acc + 16384) arithmetically shifted right by 15, using a 40-bit signed accumulator.
- R7: The rounded value saturates to the range −32768..32767.
- R8: After a non-idle slot is accepted, inReady is 0 for the next 17 cycles. outValid is 1 for exactly one cycle, in the cycle where inReady returns to 1, and outStage and outData are valid in that cycle.
- R9: While inReady is 0, inValid and inData are ignored, and no sample enters any history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Top-rate input sample present |
| inData | input | 16 | Signed top-rate input sample |
| inReady | output | 1 | Engine idle, sample can be accepted |
| outValid | output | 1 | One-cycle strobe for a stage result |
| outStage | output | 4 | Index of the stage that produced outData |
| outData | output | 16 | Signed rounded and saturated stage result |

## Verification
Two functions meet on neighbouring edges. A stage's result is written into the next stage's history in the same cycle that the output strobe is raised and inReady returns. The next accepted sample then opens a slot that may serve that very next stage, so its MAC reads a history word written one edge earlier. The bench provokes this by holding inValid high for more than 2048 samples, which covers every stage and the idle slot. A behavioural queue model predicts ready, strobe, stage tag and data on every clock, with a second instance at higher gain to drive saturation.

// File: rtl/octdec_pkg.sv
package octdec_pkg;

  typedef struct packed {
    logic loadIn;   // accept a top-rate sample into stage 0
    logic clrAcc;   // start of a new slot
    logic macStep;  // one tap product this cycle
    logic finish;   // round, write back, emit
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_DONE = 2'd2
  } engState_t;

  // Triangular coefficient set shared by every stage
  function automatic int coefTri(input int idx, input int ntap, input int unitGain);
    int half;
    half = ntap / 2;
    return unitGain * ((idx < half) ? (idx + 1) : (ntap - idx));
  endfunction

endpackage

// File: rtl/octdec_ctrl.sv
module octdec_ctrl
  import octdec_pkg::*;
#(
  parameter int NumStages = 11,
  parameter int NumTaps   = 16,
  localparam int StageW   = $clog2(NumStages),
  localparam int TapW     = $clog2(NumTaps),
  localparam int SlotW    = NumStages
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  output ctrlStrobes_t      strobes,
  output logic [TapW-1:0]   tapIdx,
  output logic [StageW-1:0] stageSel
);

  engState_t         state;
  logic [SlotW-1:0]  slotCnt;
  logic [SlotW-1:0]  nextSlot;
  logic [StageW-1:0] nextStage;
  logic              accept;

  assign inReady  = (state == ST_IDLE);
  assign accept   = inValid && inReady;
  assign nextSlot = slotCnt + SlotW'(1);

  // ruler schedule: stage = trailing zero count of the slot number
  always_comb begin
    nextStage = '0;
    for (int i = SlotW - 1; i >= 0; i--) begin
      if (nextSlot[i]) nextStage = StageW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slotCnt  <= '0;
      tapIdx   <= '0;
      stageSel <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            slotCnt <= nextSlot;
            if (|nextSlot) begin
              stageSel <= nextStage;
              tapIdx   <= '0;
              state    <= ST_MAC;
            end
          end
        end
        ST_MAC: begin
          tapIdx <= tapIdx + TapW'(1);
          if (tapIdx == TapW'(NumTaps - 1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadIn  = accept;
    strobes.clrAcc  = accept;
    strobes.macStep = (state == ST_MAC);
    strobes.finish  = (state == ST_DONE);
  end

endmodule

// File: rtl/octdec_dpath.sv
module octdec_dpath
  import octdec_pkg::*;
#(
  parameter int NumStages = 11,
  parameter int NumTaps   = 16,
  parameter int DataW     = 16,
  parameter int CoefW     = 16,
  parameter int AccW      = 40,
  parameter int FracBits  = 15,
  parameter int CoefUnit  = 455,
  localparam int StageW   = $clog2(NumStages),
  localparam int TapW     = $clog2(NumTaps),
  localparam int ProdW    = DataW + CoefW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctrlStrobes_t            strobes,
  input  logic [TapW-1:0]         tapIdx,
  input  logic [StageW-1:0]       stageSel,
  input  logic signed [DataW-1:0] inData,
  output logic                    outValid,
  output logic [StageW-1:0]       outStage,
  output logic signed [DataW-1:0] outData
);

  localparam logic signed [AccW-1:0] SatHi     = AccW'((64'sd1 <<< (DataW - 1)) - 64'sd1);
  localparam logic signed [AccW-1:0] SatLo     = -SatHi - AccW'(1);
  localparam logic signed [AccW-1:0] RoundBias = AccW'(64'sd1 <<< (FracBits - 1));

  logic signed [DataW-1:0] histLine [NumStages][NumTaps];
  logic                    shiftEn  [NumStages];
  logic signed [DataW-1:0] shiftVal [NumStages];

  logic signed [AccW-1:0]  acc;
  logic signed [CoefW-1:0] coefVal;
  logic signed [DataW-1:0] tapSample;
  logic signed [ProdW-1:0] prod;
  logic signed [AccW-1:0]  biased;
  logic signed [AccW-1:0]  shifted;
  logic signed [DataW-1:0] satVal;

  assign coefVal   = CoefW'(coefTri(int'(tapIdx), NumTaps, CoefUnit));
  assign tapSample = histLine[stageSel][tapIdx];
  assign prod      = tapSample * coefVal;

  always_ff @(posedge clk) begin
    if (rst || strobes.clrAcc) acc <= '0;
    else if (strobes.macStep)  acc <= acc + {{(AccW - ProdW){prod[ProdW-1]}}, prod};
  end

  assign biased  = acc + RoundBias;
  assign shifted = biased >>> FracBits;

  always_comb begin
    if (shifted > SatHi)      satVal = SatHi[DataW-1:0];
    else if (shifted < SatLo) satVal = SatLo[DataW-1:0];
    else                      satVal = shifted[DataW-1:0];
  end

  // write sources: stage 0 takes the input, stage s takes stage s-1 results
  always_comb begin
    shiftEn[0]  = strobes.loadIn;
    shiftVal[0] = inData;
    for (int s = 1; s < NumStages; s++) begin
      shiftEn[s]  = strobes.finish && (stageSel == StageW'(s - 1));
      shiftVal[s] = satVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NumStages; s++)
        for (int t = 0; t < NumTaps; t++)
          histLine[s][t] <= '0;
    end else begin
      for (int s = 0; s < NumStages; s++) begin
        if (shiftEn[s]) begin
          histLine[s][0] <= shiftVal[s];
          for (int t = 1; t < NumTaps; t++) histLine[s][t] <= histLine[s][t-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outStage <= '0;
      outData  <= '0;
    end else begin
      outValid <= strobes.finish;
      if (strobes.finish) begin
        outStage <= stageSel;
        outData  <= satVal;
      end
    end
  end

endmodule

// File: rtl/octdec_bank.sv
module octdec_bank
  import octdec_pkg::*;
#(
  parameter int NumStages = 11,
  parameter int NumTaps   = 16,
  parameter int DataW     = 16,
  parameter int CoefW     = 16,
  parameter int AccW      = 40,
  parameter int FracBits  = 15,
  parameter int CoefUnit  = 455,
  localparam int StageW   = $clog2(NumStages),
  localparam int TapW     = $clog2(NumTaps)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [DataW-1:0] inData,
  output logic                    inReady,
  output logic                    outValid,
  output logic [StageW-1:0]       outStage,
  output logic signed [DataW-1:0] outData
);

  ctrlStrobes_t      strobes;
  logic [TapW-1:0]   tapIdx;
  logic [StageW-1:0] stageSel;

  octdec_ctrl #(.NumStages(NumStages), .NumTaps(NumTaps)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .strobes(strobes), .tapIdx(tapIdx), .stageSel(stageSel)
  );

  octdec_dpath #(
    .NumStages(NumStages), .NumTaps(NumTaps), .DataW(DataW), .CoefW(CoefW),
    .AccW(AccW), .FracBits(FracBits), .CoefUnit(CoefUnit)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .tapIdx(tapIdx), .stageSel(stageSel),
    .inData(inData), .outValid(outValid), .outStage(outStage), .outData(outData)
  );

endmodule

// File: rtl/octdec_chk.sv
module octdec_chk #(
  parameter int NumStages = 11,
  localparam int StageW   = $clog2(NumStages)
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic [StageW-1:0] outStage
);

  // R1: reset leaves the engine idle with no result pending
  p_idle_after_reset_r1: assert property (@(posedge clk) rst |=> (inReady && !outValid));

  // R2: a tagged stage index never exceeds the last stage
  p_stage_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outStage < StageW'(NumStages)));

  // R8: a result is presented when the engine has just become ready again
  p_out_with_ready_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> inReady);

  // R8: the result strobe lasts one cycle
  p_out_single_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R8: a result always ends a busy period
  p_out_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(!inReady));

  // R9: while busy, a presented sample does not end the busy period early
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (!inReady && inValid && !$past(!inReady)) |=> !inReady);

endmodule

bind octdec_bank octdec_chk #(.NumStages(NumStages)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outStage(outStage)
);

// File: tb/sim_octdec_bank.sv
module sim_octdec_bank;

  localparam int NS = 11;
  localparam int NT = 16;
  localparam int UA = 455;
  localparam int UB = 1200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [15:0] inData = '0;
  logic rdyA, rdyB, ovA, ovB;
  logic [3:0] stA, stB;
  logic signed [15:0] odA, odB;

  always #10 clk = ~clk;

  octdec_bank u0 (.clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inReady(rdyA), .outValid(ovA), .outStage(stA), .outData(odA));

  octdec_bank #(.CoefUnit(UB)) u1 (.clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inReady(rdyB), .outValid(ovB), .outStage(stB), .outData(odB));

  int checks = 0;
  int failures = 0;

  int histA [NS][NT];
  int histB [NS][NT];
  int slotM, busyLeft, acceptedN, pendStage, pendA, pendB;
  bit expReady, prevDrive, pending, sinceReset;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int coefM(input int t, input int u);
    return u * ((t < NT/2) ? t + 1 : NT - t);
  endfunction

  function automatic int tzM(input int v);
    int n = 0;
    while (((v >> n) & 1) == 0) n++;
    return n;
  endfunction

  function automatic int roundSat(input longint a);
    longint r;
    r = (a + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic clearModel();
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NT; t++) begin
        histA[s][t] = 0;
        histB[s][t] = 0;
      end
    slotM = 0; busyLeft = 0; expReady = 1; prevDrive = 0; pending = 0; sinceReset = 1;
  endtask

  task automatic pushHist(input int s, input int va, input int vb);
    for (int t = NT - 1; t > 0; t--) begin
      histA[s][t] = histA[s][t-1];
      histB[s][t] = histB[s][t-1];
    end
    histA[s][0] = va;
    histB[s][0] = vb;
  endtask

  logic signed [15:0] lastDriven;
  bit idleSlotLast;

  // one clock of reference model plus comparison, then drive the next input
  task automatic tick(input bit v, input logic signed [15:0] d);
    bit expOut;
    string rtag;
    @(negedge clk);
    expOut = 0;
    idleSlotLast = 0;
    if (prevDrive && expReady) begin
      acceptedN++;
      pushHist(0, int'(lastDriven), int'(lastDriven));          // R4
      slotM = (slotM + 1) % 2048;
      if (slotM != 0) begin
        longint aA, aB;
        aA = 0; aB = 0;
        pendStage = tzM(slotM);
        for (int t = 0; t < NT; t++) begin
          aA += longint'(coefM(t, UA)) * longint'(histA[pendStage][t]);
          aB += longint'(coefM(t, UB)) * longint'(histB[pendStage][t]);
        end
        pendA = roundSat(aA);
        pendB = roundSat(aB);
        if (pendStage < NS - 1) pushHist(pendStage + 1, pendA, pendB);
        pending = 1;
        busyLeft = 17;
      end else begin
        idleSlotLast = 1;
      end
    end else if (busyLeft > 0) begin
      busyLeft--;
      if (busyLeft == 0 && pending) begin
        expOut = 1;
        pending = 0;
      end
    end
    expReady = (busyLeft == 0);
    // R9 when a sample was offered during a busy cycle, R3 after an idle slot
    rtag = idleSlotLast ? "R3 ready after idle slot" :
           (prevDrive && !expReady) ? "R9 R8 ready while busy" : "R8 ready";
    chk(rdyA == expReady, rtag, rdyA, expReady);
    chk(rdyB == expReady, rtag, rdyB, expReady);
    chk(ovA == expOut, idleSlotLast ? "R3 no output on idle slot" : "R8 outValid", ovA, expOut);
    chk(ovB == expOut, "R8 outValid u1", ovB, expOut);
    if (expOut) begin
      chk(int'(stA) == pendStage, "R2 stage tag", stA, pendStage);
      chk(int'(stB) == pendStage, "R2 stage tag u1", stB, pendStage);
      if (sinceReset)
        chk(int'(odA) == pendA, "R1 first result from cleared history", odA, pendA);
      else if (pendStage == 0)
        chk(int'(odA) == pendA, "R5 R6 stage 0 data", odA, pendA);
      else
        chk(int'(odA) == pendA, "R4 R5 cascaded data", odA, pendA);
      chk(int'(odB) == pendB, "R7 saturated data u1", odB, pendB);
      sinceReset = 0;
    end
    inValid = v;
    inData = d;
    lastDriven = d;
    prevDrive = v;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clearModel();
    // R1: idle state straight out of reset
    chk(rdyA == 1'b1, "R1 ready after reset", rdyA, 1);
    chk(ovA == 1'b0, "R1 outValid after reset", ovA, 0);
    chk(rdyB == 1'b1, "R1 ready after reset u1", rdyB, 1);
  endtask

  initial begin
    acceptedN = 0;
    clearModel();
    doReset();
    // continuous pressure past one full slot-counter period (R2, R3, R4, R5, R6, R7)
    while (acceptedN < 2100) tick(1'b1, 16'($urandom));
    // gaps in the input stream; valid also offered while busy (R9)
    for (int i = 0; i < 6000; i++) tick(1'($urandom % 3 != 0), 16'($urandom));
    // mid-run reset then small known samples (R1)
    doReset();
    tick(1'b1, 16'sd1000);
    for (int i = 0; i < 40; i++) tick(1'b1, 16'sd1000);
    // full-scale alternating input for rounding edges and saturation (R6, R7)
    for (int i = 0; i < 4000; i++) tick(1'b1, (i % 4 < 2) ? 16'sh7fff : 16'sh8000);
    for (int i = 0; i < 40; i++) tick(1'b0, 16'sd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule